// File: doc/BRIEF.md
# Carry-less pairwise-product hash datapath

This block computes a keyed hash over binary polynomials. A message arrives as a stream of pairs; each pair brings an odd-position message block, its key block, an even-position message block and its key block, all `W` bits wide. The key is mixed into each message block by XOR, the two mixed blocks are multiplied as polynomials over GF(2) with no reduction, and the `2W`-bit product is XOR-accumulated into the running hash.

The multiplication is bit-serial: one bit of the even operand is consumed per clock, so each pair occupies the datapath for exactly `W` cycles. The partial products are folded straight into the register that holds the running hash, so no separate product register and no carry storage exist. A de Bruijn-extended LFSR counts the `W` steps. The hash is read on `hash_out` whenever the block is ready; `done` pulses once after the product of a pair flagged as last.

Top module: `clmul_pair_hash`

## Requirements
- R1: After reset, `pair_ready` is 1, `done` is 0 and `hash_out` is all zeros.
- R2: A pair is taken on a rising clock edge where `pair_valid` and `pair_ready` are both 1; `pair_ready` is 0 during the product cycles that follow.
- R3: The odd operand is `msg_odd XOR key_odd` and the even operand is `msg_even XOR key_even`, bit by bit.
- R4: Each pair contributes the full `2W`-bit carry-less (GF(2) polynomial) product of its two operands, with no modular reduction; bit i of the operands is the coefficient of x^i.
- R5: Contributions of successive pairs combine by XOR into `hash_out`.
- R6: A pair occupies the datapath for exactly `W` cycles after the accepting edge; `pair_ready` is 1 again in the following cycle, so a pair held valid is taken with no gap.
- R7: A pair taken with `pair_start` = 1 discards the previous hash before adding its product; a pair taken with `pair_start` = 0 adds onto the hash left by the previous pair, even after `done`.
- R8: `done` is 1 for exactly one cycle, the cycle after the last product step of a pair taken with `pair_last` = 1, and stays 0 for pairs taken with `pair_last` = 0.
- R9: While `pair_ready` is 1 with no pair taken, `hash_out` holds its value; inputs presented while `pair_ready` is 0 have no effect on the result.
- R10: A pair whose message block equals its key block on either side contributes nothing to the hash.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pair_valid | input | 1 | A pair is presented |
| pair_ready | output | 1 | Datapath idle, a pair can be taken |
| pair_start | input | 1 | This pair opens a new message |
| pair_last | input | 1 | This pair closes the message |
| msg_odd | input | W | Odd-position message block |
| key_odd | input | W | Odd-position key block |
| msg_even | input | W | Even-position message block |
| key_even | input | W | Even-position key block |
| done | output | 1 | One-cycle pulse, hash of the message complete |
| hash_out | output | 2W | Accumulated 2W-bit hash, valid while pair_ready is 1 |

## Verification
The embedded properties watch every cycle for the timing skeleton: that a product lasts exactly `W` cycles, that `done` is a single-cycle pulse only seen when idle, that a start pair empties the accumulator and that an idle accumulator does not move. Whether the accumulated value is the right polynomial, that is key mixing, carry-less product bits, XOR combination across pairs and continuation after `done`, is visible only through the bench's reference model across its scenarios: random and all-ones operands, multi-pair messages, back-to-back pairs, junk inputs while busy and cancelling key blocks.

// File: rtl/chp_pkg.sv
package chp_pkg;

    typedef struct packed {
        logic busy;
        logic last;
        logic done;
    } ctrl_t;

    // One step of a de Bruijn-extended Fibonacci LFSR of width cw (cw <= 8).
    // The extra term lets the sequence pass through the all-zero state,
    // giving a period of 2**cw.
    function automatic logic [7:0] lfsr_adv(input logic [7:0] s,
                                            input int unsigned cw,
                                            input logic [7:0] taps);
        logic [7:0] rest_mask;
        logic [7:0] full_mask;
        logic       fb;
        rest_mask = 8'((9'd1 << (cw - 1)) - 9'd1);
        full_mask = 8'((9'd1 << cw) - 9'd1);
        fb        = ^(s & taps);
        if ((s & rest_mask) == 8'd0) begin
            fb = ~fb;
        end
        return ((s << 1) | {7'd0, fb}) & full_mask;
    endfunction

endpackage

// File: rtl/chp_key_mix.sv
module chp_key_mix #(
    parameter int unsigned W = 64
) (
    input  logic [W-1:0] blk,
    input  logic [W-1:0] key,
    output logic [W-1:0] mixed
);
    // Addition of polynomials over GF(2): a bank of W XOR gates.
    always_comb begin
        mixed = blk ^ key;
    end
endmodule

// File: rtl/chp_step_counter.sv
module chp_step_counter #(
    parameter int unsigned STEPS = 64,
    parameter logic [7:0]  TAPS  = 8'b0011_0000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic last_step
);
    import chp_pkg::*;

    localparam int unsigned CW = $clog2(STEPS);
    localparam logic [7:0]  SEED = 8'd1;

    function automatic logic [7:0] final_state();
        logic [7:0] s;
        s = SEED;
        for (int i = 0; i < int'(STEPS) - 1; i++) begin
            s = lfsr_adv(s, CW, TAPS);
        end
        return s;
    endfunction

    localparam logic [7:0] FINAL = final_state();

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = SEED[CW-1:0];
        end else if (run) begin
            cnt_d = CW'(lfsr_adv(8'(cnt_q), CW, TAPS));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= SEED[CW-1:0];
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign last_step = (cnt_q == FINAL[CW-1:0]);

    AST_LOAD_RESEEDS: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == SEED[CW-1:0])) else $error("counter reseed"); // R6
endmodule

// File: rtl/chp_clmul_acc.sv
module chp_clmul_acc #(
    parameter int unsigned W = 64
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           clear,
    input  logic           run,
    input  logic [W-1:0]   opa,
    input  logic [W-1:0]   opb,
    output logic [2*W-1:0] acc
);
    localparam int unsigned AW = 2 * W;

    typedef struct packed {
        logic [W-1:0]  mcand;
        logic [W-1:0]  mplier;
        logic [AW-1:0] acc;
    } st_t;

    st_t st_d, st_q;
    logic [AW-1:0] folded;

    // Right-shift multiply merged with accumulation. The register rotates
    // right once per step, so over W steps its previous content is rotated
    // by W (a half swap). Swapping the halves at load cancels that.
    always_comb begin
        st_d   = st_q;
        folded = st_q.acc ^ (st_q.mplier[0] ? {st_q.mcand, {W{1'b0}}} : {AW{1'b0}});
        if (load) begin
            st_d.mcand  = opa;
            st_d.mplier = opb;
            st_d.acc    = clear ? {AW{1'b0}} : {st_q.acc[W-1:0], st_q.acc[AW-1:W]};
        end else if (run) begin
            st_d.mplier = st_q.mplier >> 1;
            st_d.acc    = {folded[0], folded[AW-1:1]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc = st_q.acc;

    AST_START_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (load && clear) |=> (acc == {AW{1'b0}})) else $error("start clear"); // R7
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !run) |=> $stable(acc)) else $error("idle hold"); // R9
endmodule

// File: rtl/clmul_pair_hash.sv
module clmul_pair_hash #(
    parameter int unsigned W    = 64,
    parameter logic [7:0]  TAPS = 8'b0011_0000
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pair_valid,
    output logic           pair_ready,
    input  logic           pair_start,
    input  logic           pair_last,
    input  logic [W-1:0]   msg_odd,
    input  logic [W-1:0]   key_odd,
    input  logic [W-1:0]   msg_even,
    input  logic [W-1:0]   key_even,
    output logic           done,
    output logic [2*W-1:0] hash_out
);
    import chp_pkg::*;

    localparam int unsigned SPW = $clog2(W) + 1;

    ctrl_t ctrl_d, ctrl_q;
    logic [W-1:0] mix [2];
    logic         take;
    logic         fin;

    generate
        for (genvar g = 0; g < 2; g++) begin : g_lane
            chp_key_mix #(.W(W)) i_mix (
                .blk   (g == 0 ? msg_odd : msg_even),
                .key   (g == 0 ? key_odd : key_even),
                .mixed (mix[g])
            );
        end
    endgenerate

    assign pair_ready = !ctrl_q.busy;
    assign take       = pair_valid && pair_ready;

    chp_step_counter #(.STEPS(W), .TAPS(TAPS)) i_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (take),
        .run       (ctrl_q.busy),
        .last_step (fin)
    );

    chp_clmul_acc #(.W(W)) i_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (take),
        .clear (pair_start),
        .run   (ctrl_q.busy),
        .opa   (mix[0]),
        .opb   (mix[1]),
        .acc   (hash_out)
    );

    always_comb begin
        ctrl_d      = ctrl_q;
        ctrl_d.done = 1'b0;
        if (take) begin
            ctrl_d.busy = 1'b1;
            ctrl_d.last = pair_last;
        end else if (ctrl_q.busy && fin) begin
            ctrl_d.busy = 1'b0;
            ctrl_d.done = ctrl_q.last;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign done = ctrl_q.done;

    // Checker state: product cycles seen since the pair was taken.
    logic [SPW-1:0] span_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            span_q <= '0;
        end else if (take) begin
            span_q <= '0;
        end else if (ctrl_q.busy) begin
            span_q <= span_q + 1'b1;
        end
    end

    AST_SPAN_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctrl_q.busy) |-> (span_q == SPW'(W))) else $error("span"); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("done width"); // R8
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> pair_ready) else $error("done while busy"); // R8
    AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !pair_ready) else $error("ready during product"); // R2
endmodule

// File: tb/test_clmul_pair_hash.sv
`timescale 1ns/1ps
module test_clmul_pair_hash;
    localparam int W = 64;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           pair_valid = 1'b0;
    logic           pair_ready;
    logic           pair_start = 1'b0;
    logic           pair_last = 1'b0;
    logic [W-1:0]   msg_odd = '0, key_odd = '0, msg_even = '0, key_even = '0;
    logic           done;
    logic [2*W-1:0] hash_out;

    int n_run = 0;
    int n_fail = 0;
    string tag = "R1";

    always #4 clk = ~clk;

    clmul_pair_hash i_clmul_pair_hash (
        .clk(clk), .rst_n(rst_n), .pair_valid(pair_valid), .pair_ready(pair_ready),
        .pair_start(pair_start), .pair_last(pair_last), .msg_odd(msg_odd),
        .key_odd(key_odd), .msg_even(msg_even), .key_even(key_even),
        .done(done), .hash_out(hash_out)
    );

    function automatic logic [2*W-1:0] gf2_mul(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [2*W-1:0] r = '0;
        for (int i = 0; i < W; i++) begin
            if (b[i]) r ^= ({{W{1'b0}}, a} << i);
        end
        return r;
    endfunction

    // Behavioural reference model
    int             m_left = 0;
    logic           m_lastp = 1'b0;
    logic           m_done = 1'b0;
    logic [2*W-1:0] m_hash = '0;
    logic [2*W-1:0] m_next = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_left = 0; m_done = 1'b0; m_hash = '0; m_lastp = 1'b0;
        end else begin
            m_done = 1'b0;
            if (m_left > 0) begin
                m_left = m_left - 1;
                if (m_left == 0) begin
                    m_hash = m_next;
                    m_done = m_lastp;
                end
            end else if (pair_valid) begin
                m_next  = (pair_start ? '0 : m_hash) ^
                          gf2_mul(msg_odd ^ key_odd, msg_even ^ key_even);
                m_left  = W;
                m_lastp = pair_last;
            end
        end
    end

    // Compare on every falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            n_run++;
            if (pair_ready !== (m_left == 0)) begin
                n_fail++;
                $display("FAIL %s/R2/R6 pair_ready got %b exp %b", tag, pair_ready, m_left == 0);
            end
            n_run++;
            if (done !== m_done) begin
                n_fail++;
                $display("FAIL %s/R8 done got %b exp %b", tag, done, m_done);
            end
            if (m_left == 0) begin
                n_run++;
                if (hash_out !== m_hash) begin
                    n_fail++;
                    $display("FAIL %s hash got %h exp %h", tag, hash_out, m_hash);
                end
            end
        end
    end

    task automatic send(input logic [W-1:0] mo, ko, me, ke, input logic st, ls);
        logic was_ready;
        @(negedge clk);
        msg_odd = mo; key_odd = ko; msg_even = me; key_even = ke;
        pair_start = st; pair_last = ls; pair_valid = 1'b1;
        do begin
            was_ready = pair_ready;
            @(posedge clk);
        end while (!was_ready);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        pair_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [W-1:0] rnd();
        return {$urandom(), $urandom()};
    endfunction

    initial begin
        #(200000 * 8);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [W-1:0] k;
        repeat (3) @(negedge clk);
        // R1: reset state
        n_run++;
        if (pair_ready !== 1'b1 || done !== 1'b0 || hash_out !== '0) begin
            n_fail++;
            $display("FAIL R1 reset got ready=%b done=%b hash=%h exp 1 0 0", pair_ready, done, hash_out);
        end
        rst_n = 1'b1;
        idle(2);

        tag = "R3/R4";   // single random pair, key mixing and carry-less product
        send(rnd(), rnd(), rnd(), rnd(), 1'b1, 1'b1);
        idle(W + 4);

        tag = "R4";      // all-ones operands: highest product degree
        send('1, '0, '0, '1, 1'b1, 1'b1);
        idle(W + 4);

        tag = "R5/R6";   // four-pair message, back to back
        send(rnd(), rnd(), rnd(), rnd(), 1'b1, 1'b0);
        send(rnd(), rnd(), rnd(), rnd(), 1'b0, 1'b0);
        send(rnd(), rnd(), rnd(), rnd(), 1'b0, 1'b0);
        send(rnd(), rnd(), rnd(), rnd(), 1'b0, 1'b1);
        idle(W + 4);

        tag = "R7";      // continue after done without start
        send(rnd(), rnd(), rnd(), rnd(), 1'b0, 1'b1);
        idle(W + 4);

        tag = "R7";      // start discards the old hash
        send(64'h1, 64'h0, 64'h8000_0000_0000_0000, 64'h0, 1'b1, 1'b1);
        idle(W + 4);

        tag = "R9";      // junk while busy is ignored
        send(rnd(), rnd(), rnd(), rnd(), 1'b1, 1'b1);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            msg_odd = rnd(); key_odd = rnd(); msg_even = rnd(); key_even = rnd();
            pair_start = i[0]; pair_last = i[1];
        end
        idle(W);

        tag = "R10";     // cancelling key blocks add nothing
        k = rnd();
        send(k, k, rnd(), rnd(), 1'b0, 1'b0);
        send(rnd(), rnd(), k, k, 1'b0, 1'b1);
        idle(W + 4);

        tag = "R8";      // non-last pair: no done
        send(rnd(), rnd(), rnd(), rnd(), 1'b1, 1'b0);
        idle(W + 6);

        for (int t = 0; t < 6; t++) begin
            tag = "R5";
            send(rnd(), rnd(), rnd(), rnd(), t == 0, t == 5);
        end
        idle(W + 4);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule